// File: doc/BRIEF.md
# Multi-Word Mailbox Message Streamer

This block moves variable-length messages of 32-bit words between a 32-entry local buffer and a messaging unit with four transmit and four receive data registers. The first word of each message is a header whose size field gives the word count of the whole message. On transmit the block reads the header from buffer entry 0 and checks the size. It then stripes the words over the transmit registers in rotating order, waiting for a register to drain before it reuses one. On receive it takes the header from receive register 0, masks the receive interrupt of that register, and collects the rest of the words in the same rotating order into the buffer.

Each direction is started by a one-cycle request and finishes with a one-cycle done or error pulse. An error reports whether it came from an oversize header or from a timeout, and gives the index of the word that could not be moved. Software fills or reads the local buffer by index while the block is idle.

Top module: `mbox_msg_streamer`

## Requirements
- R1: The header size field is header bits [15:8] and counts 32-bit words including the header. A field value of 0 means a one-word message, and exactly that many words are moved.
- R2: A size above MAX_WORDS (31) causes an error pulse one cycle after the start, with err_idx 0 and err_timeout 0. On transmit no data register is written. On receive no done pulse is given.
- R3: Word i of a message uses data register i mod 4. Transmit drives buffer entry i on mu_tx_data. Receive stores mu_rx_data into buffer entry i. At most one word moves per cycle.
- R4: On transmit, words 0 to 3 are written without looking at status. Every later word is written only in a cycle in which mu_tx_empty of its register is 1.
- R5: In the cycle where a receive starts, the header is read from register 0 without a status check. rx_irq_en, which is 1 after reset, is 0 from the next cycle on. It returns to 1 together with the rx_done pulse, and stays 0 after a receive error.
- R6: On receive, each word after the header is read only in a cycle in which mu_rx_full of its register is 1.
- R7: If a word waits TIMEOUT consecutive cycles, the transfer aborts. An error pulse follows with err_timeout 1 and err_idx equal to that word's index, and the block returns to idle.
- R8: One cycle after the last transmit write, tx_done and tx_irq_set are each high for exactly one cycle.
- R9: buf_rdata always shows buffer entry buf_idx. A host write (buf_we) takes effect only in an idle cycle with no start request, and is ignored otherwise.
- R10: busy is high while a transfer runs. If tx_start and rx_start arrive together in idle, the transmit wins. Start requests made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | Request to send the message held in the buffer |
| rx_start | input | 1 | Request to collect a message whose header waits in receive register 0 |
| busy | output | 1 | A transfer is running |
| tx_done | output | 1 | Transmit finished (pulse) |
| tx_err | output | 1 | Transmit aborted (pulse) |
| rx_done | output | 1 | Receive finished (pulse) |
| rx_err | output | 1 | Receive aborted (pulse) |
| err_idx | output | 5 | Index of the word that failed in the last error |
| err_timeout | output | 1 | Last error was a timeout (1) or an oversize header (0) |
| buf_we | input | 1 | Host write strobe for the local buffer |
| buf_idx | input | 5 | Host buffer index |
| buf_wdata | input | 32 | Host write data |
| buf_rdata | output | 32 | Buffer entry at buf_idx |
| mu_tx_we | output | 1 | Write strobe to a transmit data register |
| mu_tx_sel | output | 2 | Transmit register number |
| mu_tx_data | output | 32 | Transmit word |
| mu_tx_empty | input | 4 | Per-register transmit-empty flags |
| mu_rx_re | output | 1 | Read strobe to a receive data register |
| mu_rx_sel | output | 2 | Receive register number |
| mu_rx_data | input | 32 | Content of the selected receive register |
| mu_rx_full | input | 4 | Per-register receive-full flags |
| tx_irq_set | output | 1 | Pulse that sets the transmit interrupt enable of register 0 |
| rx_irq_en | output | 1 | Receive interrupt enable of register 0 |

## Verification
The bench builds the block with TIMEOUT set to 20 and the default MAX_WORDS of 31 and four registers. With that short timeout, stalls on both sides abort within a few dozen cycles. Messages of 31 words wrap the register rotation almost eight times under slow draining, and sizes 32 and 40 test the oversize path. A far-side model drains transmit registers after a set delay and refills receive registers as they are read. Stopping either side makes a chosen word index time out.

// File: rtl/mbox_msg_streamer.sv
module mbox_msg_streamer #(
  parameter int MAX_WORDS = 31,
  parameter int NREG      = 4,
  parameter int TIMEOUT   = 4096,
  localparam int IW = $clog2(MAX_WORDS + 1),
  localparam int SW = $clog2(NREG),
  localparam int TW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_start,
  input  logic          rx_start,
  output logic          busy,
  output logic          tx_done,
  output logic          tx_err,
  output logic          rx_done,
  output logic          rx_err,
  output logic [IW-1:0] err_idx,
  output logic          err_timeout,
  input  logic          buf_we,
  input  logic [IW-1:0] buf_idx,
  input  logic [31:0]   buf_wdata,
  output logic [31:0]   buf_rdata,
  output logic          mu_tx_we,
  output logic [SW-1:0] mu_tx_sel,
  output logic [31:0]   mu_tx_data,
  input  logic [NREG-1:0] mu_tx_empty,
  output logic          mu_rx_re,
  output logic [SW-1:0] mu_rx_sel,
  input  logic [31:0]   mu_rx_data,
  input  logic [NREG-1:0] mu_rx_full,
  output logic          tx_irq_set,
  output logic          rx_irq_en
);

  typedef enum logic [1:0] {S_IDLE, S_TX, S_RX} st_t;

  st_t           st;
  logic [31:0]   mem [1<<IW];
  logic [IW-1:0] idx, last;
  logic [TW-1:0] tcnt;

  function automatic logic [7:0] nwords(input logic [31:0] h);
    return (h[15:8] == 8'd0) ? 8'd1 : h[15:8];
  endfunction

  wire [7:0]    tx_n   = nwords(mem[0]);
  wire [7:0]    rx_n   = nwords(mu_rx_data);
  wire          tx_big = tx_n > 8'(MAX_WORDS);
  wire          rx_big = rx_n > 8'(MAX_WORDS);
  wire [SW-1:0] slot   = idx[SW-1:0];
  wire          rx_hdr = (st == S_IDLE) && rx_start && !tx_start;
  wire          tx_ok  = (st == S_TX) && ((idx < IW'(NREG)) || mu_tx_empty[slot]);
  wire          rx_ok  = (st == S_RX) && mu_rx_full[slot];
  wire          expire = ((st == S_TX && !tx_ok) || (st == S_RX && !rx_ok)) &&
                         (tcnt == TW'(TIMEOUT - 1));

  assign busy       = st != S_IDLE;
  assign buf_rdata  = mem[buf_idx];
  assign mu_tx_we   = tx_ok;
  assign mu_tx_sel  = slot;
  assign mu_tx_data = mem[idx];
  assign mu_rx_re   = rx_hdr || rx_ok;
  assign mu_rx_sel  = rx_hdr ? '0 : slot;

  always_ff @(posedge clk) begin
    if (st == S_IDLE && !tx_start && !rx_start && buf_we) mem[buf_idx] <= buf_wdata;
    else if (rx_hdr)                                      mem[0]       <= mu_rx_data;
    else if (rx_ok)                                       mem[idx]     <= mu_rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; last <= '0; tcnt <= '0;
      tx_done <= 1'b0; tx_err <= 1'b0; rx_done <= 1'b0; rx_err <= 1'b0;
      tx_irq_set <= 1'b0; rx_irq_en <= 1'b1; err_idx <= '0; err_timeout <= 1'b0;
    end else begin
      tx_done <= 1'b0; tx_err <= 1'b0; rx_done <= 1'b0; rx_err <= 1'b0; tx_irq_set <= 1'b0;
      case (st)
        S_IDLE: begin
          tcnt <= '0;
          if (tx_start) begin
            if (tx_big) begin
              tx_err <= 1'b1; err_idx <= '0; err_timeout <= 1'b0;
            end else begin
              st <= S_TX; idx <= '0; last <= IW'(tx_n - 8'd1);
            end
          end else if (rx_start) begin
            if (rx_big) begin
              rx_irq_en <= 1'b0; rx_err <= 1'b1; err_idx <= '0; err_timeout <= 1'b0;
            end else if (rx_n == 8'd1) begin
              rx_done <= 1'b1; rx_irq_en <= 1'b1;
            end else begin
              rx_irq_en <= 1'b0; st <= S_RX; idx <= IW'(1); last <= IW'(rx_n - 8'd1);
            end
          end
        end
        S_TX, S_RX: begin
          if (tx_ok || rx_ok) begin
            tcnt <= '0;
            idx  <= idx + 1'b1;
            if (idx == last) begin
              st <= S_IDLE;
              if (st == S_TX) begin tx_done <= 1'b1; tx_irq_set <= 1'b1; end
              else begin rx_done <= 1'b1; rx_irq_en <= 1'b1; end
            end
          end else if (expire) begin
            st <= S_IDLE; err_idx <= idx; err_timeout <= 1'b1;
            if (st == S_TX) tx_err <= 1'b1; else rx_err <= 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_wait_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (mu_tx_we && idx >= IW'(NREG)) |-> mu_tx_empty[mu_tx_sel]);
  a_r6_wait_full: assert property (@(posedge clk) disable iff (!rst_n)
    (mu_rx_re && st == S_RX) |-> mu_rx_full[mu_rx_sel]);
  a_r5_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX) |-> !rx_irq_en);
  a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !mu_tx_we);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);
  a_r7_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tcnt < TW'(TIMEOUT)));

endmodule

// File: tb/mbox_msg_streamer_tb.sv
module mbox_msg_streamer_tb;
  localparam int TO = 20;

  logic clk = 0, rst_n = 0, tx_start = 0, rx_start = 0, buf_we = 0;
  logic [4:0]  buf_idx = 0;
  logic [31:0] buf_wdata = 0;
  logic busy, tx_done, tx_err, rx_done, rx_err, err_timeout, mu_tx_we, mu_rx_re, tx_irq_set, rx_irq_en;
  logic [4:0]  err_idx;
  logic [31:0] buf_rdata, mu_tx_data, mu_rx_data;
  logic [1:0]  mu_tx_sel, mu_rx_sel;
  logic [3:0]  txe, rxf;
  logic [31:0] rxr [4];

  always #10 clk = ~clk;

  mbox_msg_streamer #(.TIMEOUT(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .rx_start(rx_start), .busy(busy),
    .tx_done(tx_done), .tx_err(tx_err), .rx_done(rx_done), .rx_err(rx_err),
    .err_idx(err_idx), .err_timeout(err_timeout), .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .mu_tx_we(mu_tx_we), .mu_tx_sel(mu_tx_sel),
    .mu_tx_data(mu_tx_data), .mu_tx_empty(txe), .mu_rx_re(mu_rx_re), .mu_rx_sel(mu_rx_sel),
    .mu_rx_data(mu_rx_data), .mu_rx_full(rxf), .tx_irq_set(tx_irq_set), .rx_irq_en(rx_irq_en));

  assign mu_rx_data = rxr[mu_rx_sel];

  int nchk = 0, nfail = 0;
  bit fin = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    fin = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // far side of the messaging unit
  int drain = 2, wcount = 0, srcn = 0, sp = 0;
  int dcnt [4];
  logic [31:0] src [40];
  bit feed = 0, flush = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      txe <= 4'hF; rxf <= 4'h0; sp <= 0;
      for (int k = 0; k < 4; k++) begin dcnt[k] <= 0; rxr[k] <= 0; end
    end else begin
      if (mu_tx_we) begin txe[mu_tx_sel] <= 1'b0; dcnt[mu_tx_sel] <= drain; wcount <= wcount + 1; end
      for (int k = 0; k < 4; k++)
        if (!(mu_tx_we && mu_tx_sel == k) && !txe[k] && drain != 0) begin
          if (dcnt[k] <= 1) txe[k] <= 1'b1; else dcnt[k] <= dcnt[k] - 1;
        end
      if (flush) begin rxf <= 4'h0; sp <= 0; end
      else begin
        if (mu_rx_re) rxf[mu_rx_sel] <= 1'b0;
        if (feed && sp < srcn && !rxf[sp%4]) begin
          rxr[sp%4] <= src[sp]; rxf[sp%4] <= 1'b1; sp <= sp + 1;
        end
      end
    end
  end

  // behavioural reference model
  int mst, mi, mn, mt, e_idx;
  bit e_txd, e_rxd, e_txe, e_rxe, e_tie, e_rie, e_to;
  logic [31:0] mbuf [32];
  bit mv [32];

  function automatic int nw(logic [31:0] h);
    return (h[15:8] == 0) ? 1 : int'(h[15:8]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; mi = 0; mt = 0; e_idx = 0; e_to = 0; e_rie = 1;
      e_txd = 0; e_rxd = 0; e_txe = 0; e_rxe = 0; e_tie = 0;
    end else begin
      e_txd = 0; e_rxd = 0; e_txe = 0; e_rxe = 0; e_tie = 0;
      if (mst == 0) begin
        mt = 0;
        if (tx_start) begin
          if (nw(mbuf[0]) > 31) begin e_txe = 1; e_idx = 0; e_to = 0; end
          else begin mst = 1; mi = 0; mn = nw(mbuf[0]); end
        end else if (rx_start) begin
          mbuf[0] = rxr[0]; mv[0] = 1; e_rie = 0;
          if (nw(rxr[0]) > 31) begin e_rxe = 1; e_idx = 0; e_to = 0; end
          else if (nw(rxr[0]) == 1) begin e_rxd = 1; e_rie = 1; end
          else begin mst = 2; mi = 1; mn = nw(rxr[0]); end
        end else if (buf_we) begin
          mbuf[buf_idx] = buf_wdata; mv[buf_idx] = 1;
        end
      end else begin
        if ((mst == 1 && (mi < 4 || txe[mi%4])) || (mst == 2 && rxf[mi%4])) begin
          if (mst == 2) mbuf[mi] = rxr[mi%4];
          mi++; mt = 0;
          if (mi == mn) begin
            if (mst == 1) begin e_txd = 1; e_tie = 1; end else begin e_rxd = 1; e_rie = 1; end
            mst = 0;
          end
        end else if (mt == TO - 1) begin
          if (mst == 1) e_txe = 1; else e_rxe = 1;
          e_idx = mi; e_to = 1; mst = 0;
        end else mt++;
      end
    end
  end

  always @(negedge clk) if (rst_n && !fin) begin
    bit ewe, ere;
    ewe = (mst == 1) && (mi < 4 || txe[mi%4]);
    ere = (mst == 0 && rx_start && !tx_start) || (mst == 2 && rxf[mi%4]);
    chk("R4 tx write strobe", mu_tx_we, ewe);
    if (ewe) begin
      chk("R3 tx register", mu_tx_sel, mi % 4);
      chk("R3 tx word", mu_tx_data, mbuf[mi]);
    end
    chk("R6 rx read strobe", mu_rx_re, ere);
    if (ere) chk("R3 rx register", mu_rx_sel, (mst == 0) ? 0 : mi % 4);
    chk("R8 tx_done", tx_done, e_txd);
    chk("R8 tx_irq_set", tx_irq_set, e_tie);
    chk("R5 rx_irq_en", rx_irq_en, e_rie);
    chk("R7 rx_done", rx_done, e_rxd);
    chk("R2 tx_err", tx_err, e_txe);
    chk("R7 rx_err", rx_err, e_rxe);
    chk("R7 err_idx", err_idx, e_idx);
    chk("R7 err_timeout", err_timeout, e_to);
    chk("R10 busy", busy, mst != 0);
    if (mv[buf_idx]) chk("R9 buf_rdata", buf_rdata, mbuf[buf_idx]);
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic hostwr(int i, logic [31:0] d);
    buf_we = 1; buf_idx = 5'(i); buf_wdata = d; tick(); buf_we = 0;
  endtask

  function automatic logic [31:0] hdr(int sz);
    return {16'h7E11, 8'(sz), 8'h3C};
  endfunction

  task automatic load_tx(int sz, int n);
    hostwr(0, hdr(sz));
    for (int j = 1; j < n; j++) hostwr(j, 32'hD00D_0000 + (sz << 8) + j);
  endtask

  task automatic run_tx();
    tx_start = 1; tick(); tx_start = 0;
    while (!(tx_done || tx_err)) tick();
  endtask

  task automatic run_rx();
    rx_start = 1; tick(); rx_start = 0;
    while (!(rx_done || rx_err)) tick();
  endtask

  task automatic load_rx(int sz, int n);
    src[0] = hdr(sz);
    for (int j = 1; j < 40; j++) src[j] = 32'hA5E0_0000 + (sz << 8) + j;
    feed = 0; flush = 1; tick(); flush = 0; srcn = n; feed = 1;
    repeat (6) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    int w0;
    repeat (3) tick();
    rst_n = 1; tick();
    chk("R5 reset rx_irq_en", rx_irq_en, 1);
    chk("R10 reset busy", busy, 0);
    chk("R8 reset tx_done", tx_done, 0);
    for (int i = 0; i < 32; i++) hostwr(i, 32'h0B0B_0000 + i);

    // R1: size 0 means one word
    hostwr(0, hdr(0)); w0 = wcount; run_tx();
    chk("R1 size-zero word count", wcount - w0, 1);
    chk("R8 done after single word", tx_done, 1);
    repeat (4) tick();

    load_tx(3, 3); w0 = wcount; run_tx();
    chk("R1 three-word count", wcount - w0, 3);
    repeat (6) tick();

    // R4 / R9: long message with slow drain, host write while busy
    drain = 3; load_tx(31, 31); w0 = wcount;
    tx_start = 1; tick(); tx_start = 0;
    buf_we = 1; buf_idx = 7; buf_wdata = 32'hDEAD_BEEF;
    while (!(tx_done || tx_err)) tick();
    buf_we = 0; #1;
    chk("R9 write while busy ignored", buf_rdata, 32'hD00D_0000 + (31 << 8) + 7);
    chk("R4 31-word count", wcount - w0, 31);
    repeat (10) tick();

    // R2: oversize transmit
    hostwr(0, hdr(32)); w0 = wcount; tx_start = 1; tick(); tx_start = 0;
    chk("R2 oversize tx_err", tx_err, 1);
    chk("R2 oversize err_idx", err_idx, 0);
    chk("R2 oversize err_timeout", err_timeout, 0);
    tick();
    chk("R2 no words written", wcount - w0, 0);

    // R7: transmit timeout on word 4
    drain = 0; load_tx(6, 6); w0 = wcount; run_tx();
    chk("R7 tx timeout flag", tx_err, 1);
    chk("R7 tx timeout index", err_idx, 4);
    chk("R7 tx timeout kind", err_timeout, 1);
    chk("R7 words before stall", wcount - w0, 4);
    drain = 3; repeat (10) tick();

    // R5 / R1: one-word receive
    load_rx(1, 1); run_rx();
    chk("R5 one-word rx_done", rx_done, 1);
    chk("R5 mask restored", rx_irq_en, 1);
    buf_idx = 0; #1; chk("R3 rx header stored", buf_rdata, hdr(1));
    tick();

    // R6 / R3: nine-word receive
    load_rx(9, 9); run_rx();
    chk("R6 nine-word rx_done", rx_done, 1);
    for (int j = 0; j < 9; j++) begin
      buf_idx = 5'(j); #1; chk("R3 rx word in buffer", buf_rdata, src[j]);
    end
    tick();

    // R2 / R5: oversize receive keeps mask low
    load_rx(40, 1); run_rx();
    chk("R2 rx oversize error", rx_err, 1);
    chk("R2 rx oversize index", err_idx, 0);
    chk("R5 mask low after error", rx_irq_en, 0);
    tick();

    // R7: receive timeout on word 3
    load_rx(6, 3); run_rx();
    chk("R7 rx timeout flag", rx_err, 1);
    chk("R7 rx timeout index", err_idx, 3);
    chk("R7 rx timeout kind", err_timeout, 1);
    tick();

    // R10: simultaneous starts, transmit wins, rx start ignored while busy
    load_tx(2, 2); load_rx(2, 2); w0 = wcount;
    tx_start = 1; rx_start = 1; tick(); tx_start = 0;
    while (!(tx_done || tx_err)) tick();
    rx_start = 0;
    chk("R10 transmit won", tx_done, 1);
    chk("R10 rx header untouched", rxf[0], 1);
    chk("R10 tx word count", wcount - w0, 2);
    tick();
    run_rx();
    chk("R10 later rx completes", rx_done, 1);
    chk("R5 mask back on", rx_irq_en, 1);
    repeat (3) tick();
    finish_up();
  end
endmodule